// File: doc/BRIEF.md
# I2C bit timing generator

This block turns single bit-level requests from a byte engine into correctly timed transitions on an open-drain I2C clock and data pair. It runs on a fixed 24 MHz block clock. Three 32-bit timing words set how long SCL stays low and high, where SDA may change inside the low phase, and where SDA is sampled inside the high phase. They also set how long SDA is held low before SCL falls at a START, and how long the bus stays reserved after a STOP.

The byte engine issues a START first. It then issues one data-bit request per bit, including acknowledge bits, and closes the transaction with a STOP. Each accepted request ends with a one-cycle `done` pulse. The drive outputs mean "pull the line low". The line inputs carry the wired-AND level seen on the bus, already synchronised to the block clock. When a slave holds SCL low after the block releases it, the bit is stretched. The high phase is counted only from the first cycle SCL is seen high.

The low phase carries a fixed overhead of 2 cycles and the high phase a fixed overhead of 7 cycles. Timing words are computed with these overheads subtracted. A practical setting keeps the total bit period between 25 and 1897 block cycles.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset both drive outputs are low (lines released), `done` and `busy` are 0 and `ready` is 1.
- R2: A START (`req_op` = 2'b01) accepted while idle pulls SDA low with SCL released for max(lead,1) cycles, where lead is `timing_gap[15:0]`. SCL is then pulled low, and `done` is 1 in that same cycle.
- R3: For a data bit or STOP, SCL stays low for low+2 cycles after the accepting edge, where low is `timing_lt[31:16]`. A slave holding SCL low adds its hold time to this.
- R4: SCL stays high for exactly high+7 cycles, counted from the first cycle it is observed high, where high is `timing_hr[31:16]`. Clock stretching leaves this length unchanged.
- R5: During a data bit, the new SDA drive first appears tx+2 cycles after acceptance, where tx is `timing_lt[15:0]`. If tx exceeds low+1 it is treated as low+1. A data bit of 0 drives SDA low and a 1 releases it. SDA does not change while SCL is high, except at START and STOP.
- R6: `rx_bit` captures the SDA line level in high-phase cycle rx, where rx is `timing_hr[15:0]` and cycle 0 is the first cycle SCL is seen high. If rx exceeds high+6 it is treated as high+6.
- R7: A STOP (`req_op` = 2'b11) pulls SDA low at the transmit-change point of its low phase. It then runs a full high phase and releases SDA while SCL is high, with `done` 1 in the release cycle.
- R8: After a STOP, `busy` stays 1 for max(free,1) cycles counted from the `done` cycle, where free is `timing_gap[31:16]`. A START requested in that window is ignored.
- R9: Field positions are as follows. `timing_hr` = {high, rx}, `timing_lt` = {low, tx}, `timing_gap` = {free, lead}, upper half first, each half 16 bits.
- R10: A data bit (`req_op` = 2'b10) or a STOP is accepted only after a START or a data bit has completed. A START is accepted only when idle. Any other request is ignored with no change on the outputs. `ready` is 1 exactly when idle or waiting between bits.
- R11: `done` is a single-cycle pulse. After a data bit it rises in the cycle SCL is pulled low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (24 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_hr | input | 32 | High-phase count and receive-sample point |
| timing_lt | input | 32 | Low-phase count and transmit-change point |
| timing_gap | input | 32 | Bus-free count and START lead-in count |
| req_valid | input | 1 | Request strobe, sampled each clock |
| req_op | input | 2 | 01 START, 10 data bit, 11 STOP |
| req_bit | input | 1 | Data bit value for a data-bit request |
| scl_in | input | 1 | Synchronised SCL line level |
| sda_in | input | 1 | Synchronised SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| done | output | 1 | One-cycle pulse when a request completes |
| rx_bit | output | 1 | Last sampled SDA level |
| busy | output | 1 | Block not idle (includes bus-free wait) |
| ready | output | 1 | A request of the matching kind can be accepted |

## Verification
The bench targets the edges of each counted window.

- It uses zero counts, where lead-in and bus-free must still last one cycle.
- It uses change and sample points past the end of their phase, which must clamp to the last cycle instead of never firing.
- It stretches SCL from the slave side. A design that counted the high phase from its own release instead of the observed line would produce a short high phase.
- It places a one-cycle SDA pulse at the exact sample cycle, so a sample point off by one returns the wrong bit.
- It issues START during the bus-free wait and while a transaction is open. A design that accepted either would move SDA or raise `done` where the bench expects silence.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_START = 2'b01,
        OP_BIT   = 2'b10,
        OP_STOP  = 2'b11
    } bt_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_HELD  = 3'd2,
        ST_LOW   = 3'd3,
        ST_WAITH = 3'd4,
        ST_HIGH  = 3'd5,
        ST_FREE  = 3'd6
    } bt_state_e;

endpackage

// File: rtl/i2c_bt_fields.sv
// Splits the three timing words into counter end points and clamped
// change/sample points, all expressed as zero-based cycle indices.
module i2c_bt_fields #(
    parameter int CNT_W      = 16,
    parameter int LOW_EXTRA  = 2,
    parameter int HIGH_EXTRA = 7
) (
    input  logic [2*CNT_W-1:0] hi_word,
    input  logic [2*CNT_W-1:0] lo_word,
    input  logic [2*CNT_W-1:0] gap_word,
    output logic [CNT_W:0]     low_last,
    output logic [CNT_W:0]     high_last,
    output logic [CNT_W:0]     tx_pt,
    output logic [CNT_W:0]     rx_pt,
    output logic [CNT_W:0]     lead_last,
    output logic [CNT_W:0]     free_last
);
    localparam int PW = CNT_W + 1;

    // index 0: SCL low phase, index 1: SCL high phase
    logic [CNT_W-1:0] ph_len [2];
    logic [CNT_W-1:0] ph_pt  [2];
    logic [PW-1:0]    ph_last[2];
    logic [PW-1:0]    ph_at  [2];

    // index 0: START lead-in, index 1: bus-free wait
    logic [CNT_W-1:0] win_len [2];
    logic [PW-1:0]    win_last[2];

    assign ph_len[0]  = lo_word[2*CNT_W-1:CNT_W];
    assign ph_pt[0]   = lo_word[CNT_W-1:0];
    assign ph_len[1]  = hi_word[2*CNT_W-1:CNT_W];
    assign ph_pt[1]   = hi_word[CNT_W-1:0];
    assign win_len[0] = gap_word[CNT_W-1:0];
    assign win_len[1] = gap_word[2*CNT_W-1:CNT_W];

    for (genvar g = 0; g < 2; g++) begin : g_phase
        localparam int EXTRA = (g == 0) ? LOW_EXTRA : HIGH_EXTRA;
        assign ph_last[g] = {1'b0, ph_len[g]} + PW'(EXTRA - 1);
        // a point beyond the phase end fires on the last cycle instead
        assign ph_at[g]   = ({1'b0, ph_pt[g]} > ph_last[g]) ? ph_last[g]
                                                            : {1'b0, ph_pt[g]};
    end

    for (genvar g = 0; g < 2; g++) begin : g_window
        // a zero count still lasts one cycle
        assign win_last[g] = (win_len[g] == '0) ? '0
                                                : {1'b0, win_len[g] - CNT_W'(1)};
    end

    assign low_last  = ph_last[0];
    assign high_last = ph_last[1];
    assign tx_pt     = ph_at[0];
    assign rx_pt     = ph_at[1];
    assign lead_last = win_last[0];
    assign free_last = win_last[1];

endmodule

// File: rtl/i2c_bt_seq.sv
// Bit-level sequencer: one shared counter walks lead-in, low, high and
// bus-free windows; the line drives are registered.
module i2c_bt_seq
    import i2c_bt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W:0]   low_last,
    input  logic [CNT_W:0]   high_last,
    input  logic [CNT_W:0]   tx_pt,
    input  logic [CNT_W:0]   rx_pt,
    input  logic [CNT_W:0]   lead_last,
    input  logic [CNT_W:0]   free_last,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic             req_bit,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    output logic             done,
    output logic             rx_bit,
    output logic             busy,
    output logic             ready,
    output bt_state_e        st_o
);
    localparam logic [CNT_W:0] ONE = (CNT_W + 1)'(1);

    typedef struct packed {
        bt_state_e      st;
        logic [CNT_W:0] cnt;
        logic           scl_low;
        logic           sda_low;
        logic           done;
        logic           rx;
        logic           stop;
        logic           txb;
    } seq_t;

    seq_t q, d;
    logic [CNT_W:0] hi_cur;
    logic           hi_live;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        hi_cur  = (q.st == ST_WAITH) ? '0 : q.cnt;
        hi_live = (q.st == ST_HIGH) || scl_in;

        case (q.st)
            ST_IDLE: begin
                if (req_valid && (req_op == OP_START)) begin
                    d.st      = ST_LEAD;
                    d.cnt     = '0;
                    d.sda_low = 1'b1;
                end
            end
            ST_LEAD: begin
                if (q.cnt == lead_last) begin
                    d.st      = ST_HELD;
                    d.scl_low = 1'b1;
                    d.done    = 1'b1;
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end
            ST_HELD: begin
                if (req_valid && ((req_op == OP_BIT) || (req_op == OP_STOP))) begin
                    d.st   = ST_LOW;
                    d.cnt  = '0;
                    d.stop = (req_op == OP_STOP);
                    d.txb  = req_bit;
                end
            end
            ST_LOW: begin
                if (q.cnt == tx_pt) begin
                    d.sda_low = q.stop ? 1'b1 : ~q.txb;
                end
                if (q.cnt == low_last) begin
                    d.st      = ST_WAITH;
                    d.cnt     = '0;
                    d.scl_low = 1'b0;
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end
            ST_WAITH, ST_HIGH: begin
                // the first cycle SCL is seen high is high-phase cycle 0
                if (hi_live) begin
                    if (hi_cur == rx_pt) begin
                        d.rx = sda_in;
                    end
                    if (hi_cur == high_last) begin
                        d.done = 1'b1;
                        d.cnt  = '0;
                        if (q.stop) begin
                            d.st      = ST_FREE;
                            d.sda_low = 1'b0;
                        end else begin
                            d.st      = ST_HELD;
                            d.scl_low = 1'b1;
                        end
                    end else begin
                        d.st  = ST_HIGH;
                        d.cnt = hi_cur + ONE;
                    end
                end
            end
            ST_FREE: begin
                if (q.cnt == free_last) begin
                    d.st = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign scl_drive_low = q.scl_low;
    assign sda_drive_low = q.sda_low;
    assign done          = q.done;
    assign rx_bit        = q.rx;
    assign busy          = (q.st != ST_IDLE);
    assign ready         = (q.st == ST_IDLE) || (q.st == ST_HELD);
    assign st_o          = q.st;

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
    import i2c_bt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int LOW_EXTRA  = 2,
    parameter int HIGH_EXTRA = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*CNT_W-1:0] timing_hr,
    input  logic [2*CNT_W-1:0] timing_lt,
    input  logic [2*CNT_W-1:0] timing_gap,
    input  logic               req_valid,
    input  logic [1:0]         req_op,
    input  logic               req_bit,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               scl_drive_low,
    output logic               sda_drive_low,
    output logic               done,
    output logic               rx_bit,
    output logic               busy,
    output logic               ready
);
    logic [CNT_W:0] low_last, high_last, tx_pt, rx_pt, lead_last, free_last;
    bt_state_e      seq_state;

    i2c_bt_fields #(
        .CNT_W      (CNT_W),
        .LOW_EXTRA  (LOW_EXTRA),
        .HIGH_EXTRA (HIGH_EXTRA)
    ) u_fields (
        .hi_word   (timing_hr),
        .lo_word   (timing_lt),
        .gap_word  (timing_gap),
        .low_last  (low_last),
        .high_last (high_last),
        .tx_pt     (tx_pt),
        .rx_pt     (rx_pt),
        .lead_last (lead_last),
        .free_last (free_last)
    );

    i2c_bt_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .low_last      (low_last),
        .high_last     (high_last),
        .tx_pt         (tx_pt),
        .rx_pt         (rx_pt),
        .lead_last     (lead_last),
        .free_last     (free_last),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_bit       (req_bit),
        .scl_in        (scl_in),
        .sda_in        (sda_in),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .done          (done),
        .rx_bit        (rx_bit),
        .busy          (busy),
        .ready         (ready),
        .st_o          (seq_state)
    );

endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk
    import i2c_bt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int LOW_EXTRA  = 2,
    parameter int HIGH_EXTRA = 7
) (
    input logic             clk,
    input logic             rst_n,
    input bt_state_e        st,
    input logic [CNT_W-1:0] high_cnt,
    input logic [CNT_W-1:0] low_cnt,
    input logic             scl_in,
    input logic             scl_drive_low,
    input logic             sda_drive_low,
    input logic             done,
    input logic             busy,
    input logic             ready
);
    localparam int RW = CNT_W + 2;

    logic [RW-1:0] lo_run_q, hi_run_q;
    logic [RW-1:0] lo_exp, hi_exp;

    assign lo_exp = RW'(low_cnt) + RW'(LOW_EXTRA);
    assign hi_exp = RW'(high_cnt) + RW'(HIGH_EXTRA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run_q <= '0;
            hi_run_q <= '0;
        end else begin
            lo_run_q <= (st == ST_LOW) ? lo_run_q + RW'(1) : '0;
            hi_run_q <= ((st == ST_HIGH) || ((st == ST_WAITH) && scl_in))
                        ? hi_run_q + RW'(1) : '0;
        end
    end

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_low_len: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAITH && $past(st) == ST_LOW) |-> (lo_run_q == lo_exp));

    a_r4_high_len: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HELD || st == ST_FREE) && $past(st) == ST_HIGH)
        |-> (hi_run_q == hi_exp));

    a_r5_sda_quiet_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_drive_low) && !scl_drive_low && !$past(scl_drive_low))
        |-> (done || $past(ready)));

    a_r7_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_drive_low) && !scl_drive_low && !$past(scl_drive_low))
        |-> done);

    a_r8_free_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FREE) |-> (!scl_drive_low && !sda_drive_low && busy && !ready));

endmodule

bind i2c_bit_timer i2c_bit_timer_chk #(
    .CNT_W      (CNT_W),
    .LOW_EXTRA  (LOW_EXTRA),
    .HIGH_EXTRA (HIGH_EXTRA)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .st            (seq_state),
    .high_cnt      (timing_hr[2*CNT_W-1:CNT_W]),
    .low_cnt       (timing_lt[2*CNT_W-1:CNT_W]),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .done          (done),
    .busy          (busy),
    .ready         (ready)
);

// File: tb/test_i2c_bit_timer.sv
module test_i2c_bit_timer;
    localparam logic [1:0] OPC_START = 2'b01;
    localparam logic [1:0] OPC_BIT   = 2'b10;
    localparam logic [1:0] OPC_STOP  = 2'b11;

    // columns: high, rx, low, tx, lead, free, stretch, rx pulse offset
    localparam int NV = 6;
    localparam int VEC [NV][8] = '{
        '{ 3,  2,  4,  1,  3,  5, 0, 0},
        '{ 0,  0,  0,  0,  0,  0, 0, 0},
        '{ 5, 20,  2,  9,  2,  4, 3, 0},
        '{ 4,  3,  6,  4,  5,  2, 7, 1},
        '{12,  4, 39, 14, 15, 32, 0, 0},
        '{ 2,  1,  1,  2,  1,  1, 2, 2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] timing_hr = '0, timing_lt = '0, timing_gap = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic        req_bit = 1'b0;
    logic        slave_scl_hold = 1'b0, slave_sda_low = 1'b0;
    logic        scl_line, sda_line;
    logic        scl_drive_low, sda_drive_low, done, rx_bit, busy, ready;
    int          checks = 0, bad = 0;

    always #5 clk = ~clk;

    assign scl_line = !(scl_drive_low || slave_scl_hold);
    assign sda_line = !(sda_drive_low || slave_sda_low);

    i2c_bit_timer i_i2c_bit_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .timing_hr     (timing_hr),
        .timing_lt     (timing_lt),
        .timing_gap    (timing_gap),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_bit       (req_bit),
        .scl_in        (scl_line),
        .sda_in        (sda_line),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .done          (done),
        .rx_bit        (rx_bit),
        .busy          (busy),
        .ready         (ready)
    );

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic program_words(input int h, input int rx, input int l, input int tx,
                                 input int lead, input int free);
        timing_hr  = {h[15:0], rx[15:0]};
        timing_lt  = {l[15:0], tx[15:0]};
        timing_gap = {free[15:0], lead[15:0]};
    endtask

    task automatic issue(input logic [1:0] op, input logic b);
        req_valid = 1'b1;
        req_op    = op;
        req_bit   = b;
        @(negedge clk);
        req_valid = 1'b0;
        req_op    = 2'b00;
    endtask

    task automatic do_start(input int lead);
        int n;
        issue(OPC_START, 1'b0);
        n = 0;
        while (sda_drive_low && !scl_drive_low && n < 100000) begin
            n++;
            @(negedge clk);
        end
        chk("R2", "lead-in cycles", n, imax(lead, 1));
        chk("R2", "SCL pulled after lead-in", int'(scl_drive_low), 1);
        chk("R2", "done at SCL pull", int'(done), 1);
        @(negedge clk);
        chk("R11", "done one cycle after START", int'(done), 0);
    endtask

    // one bit or STOP; returns at the sample where done is first seen
    task automatic run_phase(input logic [1:0] op, input logic b, input int stretch,
                             input int pulse_at, input logic want_sda,
                             output int lowc, output int highc, output int chg,
                             output logic dn, output logic rxv);
        int  ph;
        int  hold;
        issue(op, b);
        lowc = 0; highc = 0; chg = -1; ph = 0; hold = 0; dn = 1'b0; rxv = 1'b0;
        for (int k = 1; k < 100000; k++) begin
            if (chg < 0 && sda_drive_low == want_sda) chg = k;
            if (ph == 0) begin
                if (!scl_drive_low && hold < stretch) begin
                    slave_scl_hold = 1'b1;
                    hold++;
                end else begin
                    slave_scl_hold = 1'b0;
                end
                if (scl_drive_low || slave_scl_hold) lowc++;
                else ph = 1;
            end
            if (ph == 1) begin
                if (done || scl_drive_low) begin
                    dn  = done;
                    rxv = rx_bit;
                    slave_sda_low = 1'b0;
                    break;
                end
                highc++;
                slave_sda_low = (highc == pulse_at);
            end
            @(negedge clk);
        end
        slave_scl_hold = 1'b0;
    endtask

    task automatic wait_free(input int free);
        int b;
        b = 0;
        while (busy && b < 100000) begin
            b++;
            @(negedge clk);
        end
        chk("R8", "busy cycles after STOP", b, imax(free, 1));
        chk("R10", "ready once idle", int'(ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int lowc, highc, chg, viol;
        logic dn, rxv;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "SCL drive in reset", int'(scl_drive_low), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "SCL drive", int'(scl_drive_low), 0);
        chk("R1", "SDA drive", int'(sda_drive_low), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "ready", int'(ready), 1);
        chk("R1", "done", int'(done), 0);

        // table walk: START, data bit 1, STOP per vector
        for (int v = 0; v < NV; v++) begin
            int h, rx, l, tx, lead, free, str, off, txp, rxp;
            h = VEC[v][0]; rx = VEC[v][1]; l = VEC[v][2]; tx = VEC[v][3];
            lead = VEC[v][4]; free = VEC[v][5]; str = VEC[v][6]; off = VEC[v][7];
            txp = imin(tx, l + 1);
            rxp = imin(rx, h + 6);
            program_words(h, rx, l, tx, lead, free);
            @(negedge clk);
            do_start(lead);
            run_phase(OPC_BIT, 1'b1, str, rxp + 1 + off, 1'b0, lowc, highc, chg, dn, rxv);
            chk("R3 R9", "low phase cycles", lowc, l + 2 + str);
            chk("R4 R9", "high phase cycles", highc, h + 7);
            chk("R5", "SDA change sample", chg, txp + 2);
            chk("R6", "sampled bit", int'(rxv), (off == 0) ? 0 : 1);
            chk("R11", "done with SCL pull", int'(dn && scl_drive_low), 1);
            @(negedge clk);
            chk("R11", "done single cycle", int'(done), 0);
            run_phase(OPC_STOP, 1'b0, 0, 0, 1'b1, lowc, highc, chg, dn, rxv);
            chk("R7", "STOP SDA low point", chg, txp + 2);
            chk("R7", "STOP high phase", highc, h + 7);
            chk("R7", "STOP done", int'(dn), 1);
            chk("R7", "SDA released at STOP", int'(sda_drive_low), 0);
            chk("R7", "SCL high at STOP", int'(scl_line), 1);
            wait_free(free);
        end

        // R10: data bit and STOP while idle are ignored
        program_words(3, 2, 4, 1, 3, 5);
        issue(OPC_BIT, 1'b0);
        issue(OPC_STOP, 1'b0);
        viol = 0;
        for (int i = 0; i < 4; i++) begin
            if (scl_drive_low || sda_drive_low || done || busy) viol++;
            @(negedge clk);
        end
        chk("R10", "idle ignores bit and STOP", viol, 0);

        // R10: START while a transaction is open is ignored; R5: data bit 0
        do_start(3);
        issue(OPC_START, 1'b0);
        viol = 0;
        for (int i = 0; i < 4; i++) begin
            if (!scl_drive_low || !sda_drive_low || done || !ready) viol++;
            @(negedge clk);
        end
        chk("R10", "held state ignores START", viol, 0);
        run_phase(OPC_BIT, 1'b0, 0, 0, 1'b1, lowc, highc, chg, dn, rxv);
        chk("R5", "bit 0 keeps SDA low", int'(sda_drive_low), 1);
        chk("R3", "low phase after ignored START", lowc, 6);
        chk("R6", "bit 0 reads low line", int'(rxv), 0);
        run_phase(OPC_STOP, 1'b0, 0, 0, 1'b1, lowc, highc, chg, dn, rxv);
        chk("R7", "STOP after bit 0", int'(dn), 1);
        wait_free(5);

        // R8: START during bus-free wait is ignored
        program_words(3, 2, 4, 1, 2, 20);
        @(negedge clk);
        do_start(2);
        run_phase(OPC_STOP, 1'b0, 0, 0, 1'b1, lowc, highc, chg, dn, rxv);
        chk("R7", "STOP done before free wait", int'(dn), 1);
        issue(OPC_START, 1'b0);
        viol = 0;
        for (int i = 0; i < 100000 && busy; i++) begin
            if (sda_drive_low || scl_drive_low || done) viol++;
            @(negedge clk);
        end
        for (int i = 0; i < 3; i++) begin
            if (sda_drive_low || scl_drive_low || done || busy) viol++;
            @(negedge clk);
        end
        chk("R8", "START ignored while bus free pending", viol, 0);
        do_start(2);
        run_phase(OPC_STOP, 1'b0, 0, 0, 1'b1, lowc, highc, chg, dn, rxv);
        wait_free(20);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule